// File: doc/BRIEF.md
# Serial-bus byte memory target

This block is the target side of a two-wire serial bus (SCL clock, SDA data) in front of an on-chip byte-wide memory array. Both bus lines are oversampled by the system clock. Each line is synchronised and then filtered so that short pulses are rejected. Start and stop conditions are recognised from the filtered lines. An 8-bit selection word addresses the block, and after it the block runs write, current-pointer read, random read and sequential read transfers.

Data is stored as soon as each byte's acknowledge slot ends, so there is no busy period and no need to poll for completion. A single address pointer is kept across transfers. The pointer wraps at the top of the array. A lock input stops the array from changing. SDA is driven only as an open-drain pull-down enable.

The master reaches the block through the selection word. Bits 7:4 carry the type code 1010, bits 3:1 carry the strap value (bit 3 matches strap bit 2), and bit 0 selects read (1) or write (0). A write sends two address bytes, high byte first, and then data. Address bits above ADDR_W are discarded.

Top module: `nvm_i2c_slave`

## Requirements
- R1: A selection word whose bits 7:4 are 1010 and whose bits 3:1 equal dev_sel_i[2:0] (bit 3 against dev_sel_i[2]) is acknowledged: SDA is held low through the ninth clock.
- R2: A selection word with a different type code or strap value is not acknowledged. The block goes idle, and the bytes that follow until the next start change nothing.
- R3: A stop condition arriving before a byte's acknowledge slot has finished aborts the transfer, and that byte is not stored.
- R4: In a write, the two address bytes (high then low, only bits ADDR_W-1:0 kept) load the pointer. Each data byte is stored at the pointer when its acknowledge slot ends, and the pointer then increments.
- R5: The pointer wraps from the last location (2^ADDR_W-1) to 0, for both writes and reads.
- R6: While wr_lock_i is high, data bytes are still acknowledged and the pointer still advances, but no location changes.
- R7: A read selection word sent without address bytes returns the byte at the pointer, which is the location after the last one accessed. The pointer is 0 after reset.
- R8: A random read (write selection word, two address bytes, repeated start, read selection word) returns the byte at the given address.
- R9: During a read, the block sends the next byte for as long as the master acknowledges. After a master NACK it releases SDA until the next start or stop.
- R10: Read data goes out MSB first. SDA changes only after SCL falls, and input bits are taken on SCL rising.
- R11: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks has no effect on a transfer.
- R12: During and after reset, SDA is released (sda_oe_o = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_sel_i | input | 3 | Strap value matched against selection word bits 3:1 |
| wr_lock_i | input | 1 | High blocks every change to the array |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bench targets pointer wrap during both a multi-byte write and a sequential read. A design that saturates the pointer or fails to wrap would return the wrong byte for location 0 and for the following current-pointer read. A locked write must still be acknowledged and must leave the old byte in place; a design that NACKs would stall the master, and one that ignores the lock would overwrite the location. A stop in the middle of a byte must leave memory unchanged, which catches a design that stores partial shifts. Selection words with a wrong type or a swapped strap order must not be acknowledged. Two-cycle pulses on SCL and on SDA are injected inside a data byte: a design with a weak filter would either shift an extra bit or see a false stop.

// File: rtl/nvm_i2c_pkg.sv
package nvm_i2c_pkg;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_HOLD
    } xfer_st_e;
endpackage

// File: rtl/nvm_i2c_line_filter.sv
module nvm_i2c_line_filter #(
    parameter int FILT_LEN = 3,
    parameter bit RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          filt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[0], raw_i};
        if (flt_q.sync[1] == flt_q.filt) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(FILT_LEN - 1)) begin
            flt_d.filt = flt_q.sync[1];
            flt_d.cnt  = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '{sync: {2{RST_VAL}}, cnt: '0, filt: RST_VAL};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign filt_o = flt_q.filt;

    // R11: the filtered level only moves after FILT_LEN differing samples
    a_r11_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flt_q.filt) |-> $past(flt_q.cnt) == CW'(FILT_LEN - 1));
endmodule

// File: rtl/nvm_i2c_array.sv
module nvm_i2c_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [7:0]        wdata_i,
    input  logic              lock_i,
    output logic [7:0]        rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];

    // R6: a locked cycle leaves the addressed byte unchanged
    a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> mem_q[$past(addr_i)] == $past(mem_q[addr_i]));
endmodule

// File: rtl/nvm_i2c_xfer_fsm.sv
module nvm_i2c_xfer_fsm
    import nvm_i2c_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [2:0]        dev_sel_i,
    input  logic              wr_lock_i,
    input  logic [7:0]        rd_data_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              we_o,
    output logic [7:0]        wd_o,
    output logic              sda_oe_o
);
    typedef struct packed {
        xfer_st_e          st;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [7:0]        ahi;
        logic [ADDR_W-1:0] ptr;
        logic              rw;
        logic              oe;
        logic              mack;
        logic              scl_p;
        logic              sda_p;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic scl_rise, scl_fall, start_ev, stop_ev, commit;

    assign scl_rise = scl_f & ~fsm_q.scl_p;
    assign scl_fall = ~scl_f & fsm_q.scl_p;
    assign start_ev = scl_f & fsm_q.scl_p & fsm_q.sda_p & ~sda_f;
    assign stop_ev  = scl_f & fsm_q.scl_p & ~fsm_q.sda_p & sda_f;

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.scl_p = scl_f;
        fsm_d.sda_p = sda_f;
        commit      = 1'b0;
        if (stop_ev) begin
            fsm_d.st = ST_IDLE;
            fsm_d.oe = 1'b0;
        end else if (start_ev) begin
            fsm_d.st  = ST_DEV;
            fsm_d.cnt = '0;
            fsm_d.oe  = 1'b0;
        end else begin
            case (fsm_q.st)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise && fsm_q.cnt < 4'd8) begin
                        fsm_d.sh  = {fsm_q.sh[6:0], sda_f};
                        fsm_d.cnt = fsm_q.cnt + 4'd1;
                    end else if (scl_fall && fsm_q.cnt == 4'd8) begin
                        fsm_d.oe = 1'b1;
                        case (fsm_q.st)
                            ST_DEV: begin
                                fsm_d.rw = fsm_q.sh[0];
                                fsm_d.st = ST_DEV_ACK;
                                if (fsm_q.sh[7:4] != DEV_TYPE || fsm_q.sh[3:1] != dev_sel_i) begin
                                    fsm_d.oe = 1'b0;
                                    fsm_d.st = ST_IDLE;
                                end
                            end
                            ST_AHI:  fsm_d.st = ST_AHI_ACK;
                            ST_ALO:  fsm_d.st = ST_ALO_ACK;
                            default: fsm_d.st = ST_WDAT_ACK;
                        endcase
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        fsm_d.cnt = '0;
                        fsm_d.oe  = 1'b0;
                        fsm_d.st  = ST_AHI;
                        if (fsm_q.rw) begin
                            fsm_d.st  = ST_RDAT;
                            fsm_d.sh  = rd_data_i;
                            fsm_d.oe  = ~rd_data_i[7];
                            fsm_d.ptr = fsm_q.ptr + 1'b1;
                        end
                    end
                end
                ST_AHI_ACK: begin
                    if (scl_fall) begin
                        fsm_d.cnt = '0;
                        fsm_d.oe  = 1'b0;
                        fsm_d.ahi = fsm_q.sh;
                        fsm_d.st  = ST_ALO;
                    end
                end
                ST_ALO_ACK: begin
                    if (scl_fall) begin
                        fsm_d.cnt = '0;
                        fsm_d.oe  = 1'b0;
                        fsm_d.ptr = ADDR_W'({fsm_q.ahi, fsm_q.sh});
                        fsm_d.st  = ST_WDAT;
                    end
                end
                ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        commit    = 1'b1;
                        fsm_d.cnt = '0;
                        fsm_d.oe  = 1'b0;
                        fsm_d.ptr = fsm_q.ptr + 1'b1;
                        fsm_d.st  = ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (fsm_q.cnt == 4'd7) begin
                            fsm_d.oe = 1'b0;
                            fsm_d.st = ST_RACK;
                        end else begin
                            fsm_d.sh  = {fsm_q.sh[6:0], 1'b0};
                            fsm_d.oe  = ~fsm_q.sh[6];
                            fsm_d.cnt = fsm_q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        fsm_d.mack = ~sda_f;
                    end else if (scl_fall) begin
                        fsm_d.st = ST_HOLD;
                        if (fsm_q.mack) begin
                            fsm_d.st  = ST_RDAT;
                            fsm_d.cnt = '0;
                            fsm_d.sh  = rd_data_i;
                            fsm_d.oe  = ~rd_data_i[7];
                            fsm_d.ptr = fsm_q.ptr + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, cnt: '0, sh: '0, ahi: '0, ptr: '0, rw: 1'b0,
                       oe: 1'b0, mack: 1'b0, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign ptr_o    = fsm_q.ptr;
    assign we_o     = commit & ~wr_lock_i;
    assign wd_o     = fsm_q.sh;
    assign sda_oe_o = fsm_q.oe;

    // R10: the pull-down only moves after an SCL fall or a bus condition
    a_r10_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fsm_q.oe) |-> $past(scl_fall | start_ev | stop_ev));
    // R3: a stop always returns the engine to idle
    a_r3_stop_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> fsm_q.st == ST_IDLE);
    // R9: idle and post-NACK hold never pull SDA
    a_r9_released: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_IDLE || fsm_q.st == ST_HOLD) |-> !fsm_q.oe);
    // R12: released while reset is applied
    a_r12_reset_release: assert property (@(posedge clk)
        !rst_n |-> !sda_oe_o);
endmodule

// File: rtl/nvm_i2c_slave.sv
module nvm_i2c_slave #(
    parameter int ADDR_W   = 10,
    parameter int FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel_i,
    input  logic       wr_lock_i,
    output logic       sda_oe_o
);
    logic [1:0]        raw_lines, filt_lines;
    logic [ADDR_W-1:0] ptr;
    logic              we;
    logic [7:0]        wdata, rdata;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        nvm_i2c_line_filter #(
            .FILT_LEN(FILT_LEN),
            .RST_VAL (1'b1)
        ) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_lines[g]),
            .filt_o(filt_lines[g])
        );
    end

    nvm_i2c_xfer_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt_lines[0]),
        .sda_f    (filt_lines[1]),
        .dev_sel_i(dev_sel_i),
        .wr_lock_i(wr_lock_i),
        .rd_data_i(rdata),
        .ptr_o    (ptr),
        .we_o     (we),
        .wd_o     (wdata),
        .sda_oe_o (sda_oe_o)
    );

    nvm_i2c_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (ptr),
        .we_i   (we),
        .wdata_i(wdata),
        .lock_i (wr_lock_i),
        .rdata_o(rdata)
    );
endmodule

// File: tb/nvm_i2c_slave_test.sv
module nvm_i2c_slave_test;
    localparam int Q = 10;
    localparam int AW = 10;
    localparam logic [2:0] SEL = 3'b110;
    localparam logic [15:0] AMASK = 16'((1 << AW) - 1);
    // vector: {lock, address16, data8}
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 16'h0010, 8'h5A},
        {1'b0, 16'h0011, 8'hC3},
        {1'b0, 16'h0123, 8'h81},
        {1'b1, 16'h0010, 8'h77},
        {1'b0, 16'hC011, 8'h3C},
        {1'b0, 16'h03FE, 8'h01}
    };

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, lock = 1'b0;
    logic sda_oe, sda_line;
    int   checks = 0, errs = 0;
    logic [7:0] ref_mem [1 << AW];

    assign sda_line = sda_m & ~sda_oe;
    always #4 clk = ~clk;

    nvm_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .dev_sel_i(SEL), .wr_lock_i(lock), .sda_oe_o(sda_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic bstop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
        end
    endtask

    task automatic ack_slot(output bit acked);
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); acked = !sda_line; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        ack_slot(acked);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            qw(); scl_m = 1'b1; qw(); b = {b[6:0], sda_line}; qw(); scl_m = 1'b0; qw();
        end
        sda_m = ~mack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw(); sda_m = 1'b1;
    endtask

    task automatic set_addr(input logic [15:0] a, output bit ok);
        bit k0, k1, k2;
        bstart();
        send_byte({4'b1010, SEL, 1'b0}, k0);
        send_byte(a[15:8], k1);
        send_byte(a[7:0], k2);
        ok = k0 & k1 & k2;
    endtask

    task automatic rand_read1(input logic [15:0] a, output logic [7:0] b);
        bit ok;
        set_addr(a, ok);
        bstart();
        send_byte({4'b1010, SEL, 1'b1}, ok);
        recv_byte(1'b0, b);
        bstop();
    endtask

    initial begin : main
        bit ok, k;
        logic [7:0] rb;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R12 released in reset", 32'(sda_oe), 0);
        rst_n = 1'b1;
        qw();
        chk(sda_oe == 1'b0, "R12 released after reset", 32'(sda_oe), 0);

        // table walk: write one byte, read it back at the masked address
        for (int v = 0; v < 6; v++) begin
            logic [15:0] a;
            a = VEC[v][23:8];
            lock = VEC[v][24];
            set_addr(a, ok);
            send_byte(VEC[v][7:0], k);
            bstop();
            lock = 1'b0;
            chk(ok & k, "R1 R4 R6 all bytes acknowledged", 32'(ok & k), 1);
            if (!VEC[v][24]) ref_mem[a & AMASK] = VEC[v][7:0];
            rand_read1(a, rb);
            chk(rb == ref_mem[a & AMASK], "R4 R6 R8 R10 readback", 32'(rb), 32'(ref_mem[a & AMASK]));
        end

        // R5 wrap on write: three bytes from the last location
        set_addr(16'h03FF, ok);
        send_byte(8'hAA, k); send_byte(8'hBB, k); send_byte(8'hCC, k);
        bstop();
        set_addr(16'h03FF, ok);
        bstart();
        send_byte({4'b1010, SEL, 1'b1}, ok);
        recv_byte(1'b1, rb);
        chk(rb == 8'hAA, "R5 last location", 32'(rb), 32'hAA);
        recv_byte(1'b0, rb);
        chk(rb == 8'hBB, "R5 R9 wrapped read of location 0", 32'(rb), 32'hBB);
        qw(); qw();
        chk(sda_oe == 1'b0, "R9 released after NACK", 32'(sda_oe), 0);
        bstop();

        // R7 current-pointer read continues at location 1
        bstart();
        send_byte({4'b1010, SEL, 1'b1}, ok);
        recv_byte(1'b0, rb);
        bstop();
        chk(rb == 8'hCC, "R7 current-pointer read", 32'(rb), 32'hCC);

        // R2 wrong strap order and wrong type code
        bstart();
        send_byte({4'b1010, 3'b011, 1'b0}, k);
        chk(!k, "R2 swapped strap not acknowledged", 32'(k), 0);
        send_byte(8'h00, k); send_byte(8'h10, k); send_byte(8'h99, k);
        bstop();
        bstart();
        send_byte({4'b1011, SEL, 1'b0}, k);
        chk(!k, "R2 wrong type not acknowledged", 32'(k), 0);
        bstop();
        rand_read1(16'h0010, rb);
        chk(rb == 8'h5A, "R2 memory unchanged", 32'(rb), 32'h5A);

        // R3 stop inside a data byte
        set_addr(16'h0123, ok);
        send_bits(8'hEE, 5);
        bstop();
        rand_read1(16'h0123, rb);
        chk(rb == 8'h81, "R3 aborted byte not stored", 32'(rb), 32'h81);

        // R11 short pulses on SCL (low phase) and SDA (high phase) inside 0x42
        set_addr(16'h0200, ok);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 8'h42 >> i;
            if (i == 5) begin
                @(negedge clk) scl_m = 1'b1; repeat (2) @(negedge clk); scl_m = 1'b0;
                repeat (Q - 3) @(negedge clk);
            end else begin
                qw();
            end
            scl_m = 1'b1; qw();
            if (i == 3) begin
                sda_m = 1'b1; repeat (2) @(negedge clk); sda_m = 1'b0;
                repeat (Q - 2) @(negedge clk);
            end else begin
                qw();
            end
            scl_m = 1'b0; qw();
        end
        ack_slot(k);
        bstop();
        chk(k, "R11 data byte acknowledged", 32'(k), 1);
        rand_read1(16'h0200, rb);
        chk(rb == 8'h42, "R11 pulses rejected", 32'(rb), 32'h42);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule